// File: doc/BRIEF.md
# ATA-to-serial port routing crossbar

This block sits between two parallel ATA controller channels and the physical attachment points of a chip. Each channel has a master and a slave interface, which gives four interface bundles. They can be steered to two serial adapter ports (adapter 0 and adapter 1) or to one set of external parallel pads. The parallel pads have a master slot and a slave slot. The routing is chosen by a 3-bit mode field at bits 26:24 of a 32-bit configuration register at offset 0x30. That register is written through a bit-masked write port and read back through a combinational read port.

Every path is combinational from the registered mode, so routing changes in the clock cycle after the write edge. The crossbar has these outputs besides the data paths:
- a per-channel flag that says whether the channel has any serial adapter;
- a per-adapter flag that says whether the adapter runs as the slave of the other channel.

Pad slots that the current mode does not use have their output-enable deasserted and their data driven to zero. Interfaces that have nowhere to go receive zero on their return path.

Interface index order on the bundled ports is ata0 master (0), ata0 slave (1), ata1 master (2), ata1 slave (3). Pad slot 0 is the master slot and pad slot 1 is the slave slot.

Top module: `ata_sata_xbar`

## Requirements
- R1: After reset the configuration register reads 0x0000_0000, so the mode field is 000.
- R2: A write to offset 0x30 updates only the bits set in wr_mask_i. A write to any other offset changes nothing. A read of offset 0x30 returns the register, and a read of any other offset returns 0.
- R3: In mode 000, interface 0 goes to adapter 0, interface 2 goes to adapter 1, and interface 1 goes to pad slot 1. Return data follows each path back.
- R4: In mode 001, interface 0 goes to adapter 0, interface 2 goes to adapter 1, and interface 3 goes to pad slot 1.
- R5: In mode 010, interface 3 goes to adapter 0, interface 2 goes to adapter 1, interface 0 goes to pad slot 0 and interface 1 goes to pad slot 1.
- R6: In mode 011, interface 0 goes to adapter 0, interface 1 goes to adapter 1, interface 2 goes to pad slot 0 and interface 3 goes to pad slot 1.
- R7: A write whose resulting mode field is 100 to 111 leaves the mode field at its previous value. Other masked bits of the same write are still stored.
- R8: The attached flag for channel 0 (bit 0) is low exactly in mode 010. The attached flag for channel 1 (bit 1) is low exactly in mode 011.
- R9: The adapter 0 slave flag (bit 0) is high only in mode 010. The adapter 1 slave flag (bit 1) is high only in mode 011.
- R10: A pad slot the mode does not use has its output-enable at 0 and its data at 0.
- R11: An interface that the mode routes nowhere receives all-zero return data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW (8) | Register offset for both read and write |
| wr_data_i | input | 32 | Write data |
| wr_mask_i | input | 32 | Per-bit write enable |
| rd_data_o | output | 32 | Combinational read data |
| ifc_req_i | input | 4 x DW | Controller-to-device data per interface |
| ifc_rsp_o | output | 4 x DW | Device-to-controller data per interface |
| adp_req_o | output | 2 x DW | Data toward each serial adapter |
| adp_rsp_i | input | 2 x DW | Data from each serial adapter |
| adp_slave_o | output | 2 | Adapter runs as slave of the other channel |
| pad_o | output | 2 x DW | Data toward pad slots (0 master, 1 slave) |
| pad_oe_o | output | 2 | Pad slot output-enable |
| pad_i | input | 2 x DW | Data from pad slots |
| bridge_att_o | output | 2 | Channel has a serial adapter |

## Verification
A masked write launched on one rising edge is due in the register on that same edge. The read data and every routed path therefore reflect the write from just after that edge. The bench drives each write at a falling edge and removes the strobe at the next falling edge. It then evaluates read-back, data paths, pad enables and flags one time step after the new stimulus, half a period away from any rising edge. Path inputs are changed only between rising edges. Since all routing is combinational from the mode, each data-path check is due in the same time step as its input change.

// File: rtl/ata_xbar_pkg.sv
package ata_xbar_pkg;
  localparam int N_IFC  = 4;
  localparam int N_ADP  = 2;
  localparam int N_PAD  = 2;
  localparam int N_DST  = 5;
  localparam int SRC_W  = $clog2(N_IFC);
  localparam int DST_W  = $clog2(N_DST);

  localparam logic [SRC_W-1:0] SRC_A0M = 2'd0;
  localparam logic [SRC_W-1:0] SRC_A0S = 2'd1;
  localparam logic [SRC_W-1:0] SRC_A1M = 2'd2;
  localparam logic [SRC_W-1:0] SRC_A1S = 2'd3;

  localparam logic [DST_W-1:0] DST_NONE = 3'd0;
  localparam logic [DST_W-1:0] DST_ADP0 = 3'd1;
  localparam logic [DST_W-1:0] DST_ADP1 = 3'd2;
  localparam logic [DST_W-1:0] DST_PADM = 3'd3;
  localparam logic [DST_W-1:0] DST_PADS = 3'd4;

  typedef struct packed {
    logic [N_ADP-1:0][SRC_W-1:0] adp_src;
    logic [N_PAD-1:0][SRC_W-1:0] pad_src;
    logic [N_PAD-1:0]            pad_en;
    logic [N_IFC-1:0][DST_W-1:0] ifc_dst;
    logic [N_ADP-1:0]            adp_slave;
    logic [1:0]                  attached;
  } route_t;
endpackage

// File: rtl/xbar_cfg_reg.sv
module xbar_cfg_reg #(
  parameter int          AW       = 8,
  parameter int          RW       = 32,
  parameter logic [AW-1:0] ADDR   = 8'h30,
  parameter logic [RW-1:0] RST_VAL = '0,
  parameter int          MODE_LSB = 24,
  parameter int          MODE_W   = 3,
  parameter int          N_MODES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [RW-1:0]     wr_data_i,
  input  logic [RW-1:0]     wr_mask_i,
  output logic [RW-1:0]     cfg_o,
  output logic [MODE_W-1:0] mode_o
);
  logic [RW-1:0]     cfg_q, merged, nxt;
  logic [MODE_W-1:0] cand;
  logic              hit;

  assign hit = wr_en_i && (addr_i == ADDR);

  always_comb begin
    merged = (cfg_q & ~wr_mask_i) | (wr_data_i & wr_mask_i);
    cand   = merged[MODE_LSB +: MODE_W];
    nxt    = merged;
    // reserved codes keep the old mode, rest of the write still lands
    if (32'(cand) >= N_MODES) nxt[MODE_LSB +: MODE_W] = cfg_q[MODE_LSB +: MODE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cfg_q <= RST_VAL;
    else if (hit) cfg_q <= nxt;
  end

  assign cfg_o  = cfg_q;
  assign mode_o = cfg_q[MODE_LSB +: MODE_W];
endmodule

// File: rtl/xbar_route_dec.sv
module xbar_route_dec
  import ata_xbar_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic [MODE_W-1:0] mode_i,
  output route_t            route_o
);
  always_comb begin
    route_o = '0;
    case (mode_i)
      MODE_W'(1): begin
        route_o.adp_src   = {SRC_A1M, SRC_A0M};
        route_o.pad_src   = {SRC_A1S, SRC_A0M};
        route_o.pad_en    = 2'b10;
        route_o.ifc_dst   = {DST_PADS, DST_ADP1, DST_NONE, DST_ADP0};
        route_o.adp_slave = 2'b00;
        route_o.attached  = 2'b11;
      end
      MODE_W'(2): begin
        route_o.adp_src   = {SRC_A1M, SRC_A1S};
        route_o.pad_src   = {SRC_A0S, SRC_A0M};
        route_o.pad_en    = 2'b11;
        route_o.ifc_dst   = {DST_ADP0, DST_ADP1, DST_PADS, DST_PADM};
        route_o.adp_slave = 2'b01;
        route_o.attached  = 2'b10;
      end
      MODE_W'(3): begin
        route_o.adp_src   = {SRC_A0S, SRC_A0M};
        route_o.pad_src   = {SRC_A1S, SRC_A1M};
        route_o.pad_en    = 2'b11;
        route_o.ifc_dst   = {DST_PADS, DST_PADM, DST_ADP1, DST_ADP0};
        route_o.adp_slave = 2'b10;
        route_o.attached  = 2'b01;
      end
      default: begin
        route_o.adp_src   = {SRC_A1M, SRC_A0M};
        route_o.pad_src   = {SRC_A0S, SRC_A0M};
        route_o.pad_en    = 2'b10;
        route_o.ifc_dst   = {DST_NONE, DST_ADP1, DST_PADS, DST_ADP0};
        route_o.adp_slave = 2'b00;
        route_o.attached  = 2'b11;
      end
    endcase
  end
endmodule

// File: rtl/xbar_sel.sv
module xbar_sel #(
  parameter int N  = 4,
  parameter int SW = 2,
  parameter int DW = 8
) (
  input  logic [N-1:0][DW-1:0] d_i,
  input  logic [SW-1:0]        sel_i,
  input  logic                 en_i,
  output logic [DW-1:0]        q_o
);
  logic [N-1:0][DW-1:0] term;

  for (genvar i = 0; i < N; i++) begin : g_term
    assign term[i] = d_i[i] & {DW{en_i && (32'(sel_i) == i)}};
  end

  always_comb begin
    q_o = '0;
    for (int i = 0; i < N; i++) q_o = q_o | term[i];
  end
endmodule

// File: rtl/ata_sata_xbar.sv
module ata_sata_xbar
  import ata_xbar_pkg::*;
#(
  parameter int            AW   = 8,
  parameter int            DW   = 8,
  parameter logic [AW-1:0] ADDR = 8'h30
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [31:0]            wr_data_i,
  input  logic [31:0]            wr_mask_i,
  output logic [31:0]            rd_data_o,
  input  logic [N_IFC-1:0][DW-1:0] ifc_req_i,
  output logic [N_IFC-1:0][DW-1:0] ifc_rsp_o,
  output logic [N_ADP-1:0][DW-1:0] adp_req_o,
  input  logic [N_ADP-1:0][DW-1:0] adp_rsp_i,
  output logic [N_ADP-1:0]       adp_slave_o,
  output logic [N_PAD-1:0][DW-1:0] pad_o,
  output logic [N_PAD-1:0]       pad_oe_o,
  input  logic [N_PAD-1:0][DW-1:0] pad_i,
  output logic [1:0]             bridge_att_o
);
  localparam int MODE_LSB = 24;
  localparam int MODE_W   = 3;

  logic [31:0]          cfg_q;
  logic [MODE_W-1:0]    mode_q;
  route_t               route;
  logic [N_DST-1:0][DW-1:0] dst_rsp;

  xbar_cfg_reg #(
    .AW(AW), .RW(32), .ADDR(ADDR), .RST_VAL('0),
    .MODE_LSB(MODE_LSB), .MODE_W(MODE_W), .N_MODES(4)
  ) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wr_data_i, .wr_mask_i,
    .cfg_o(cfg_q), .mode_o(mode_q)
  );

  xbar_route_dec #(.MODE_W(MODE_W)) u_dec (.mode_i(mode_q), .route_o(route));

  assign rd_data_o = (addr_i == ADDR) ? cfg_q : '0;

  for (genvar a = 0; a < N_ADP; a++) begin : g_adp
    xbar_sel #(.N(N_IFC), .SW(SRC_W), .DW(DW)) u_sel (
      .d_i(ifc_req_i), .sel_i(route.adp_src[a]), .en_i(1'b1), .q_o(adp_req_o[a])
    );
  end

  for (genvar p = 0; p < N_PAD; p++) begin : g_pad
    xbar_sel #(.N(N_IFC), .SW(SRC_W), .DW(DW)) u_sel (
      .d_i(ifc_req_i), .sel_i(route.pad_src[p]), .en_i(route.pad_en[p]), .q_o(pad_o[p])
    );
  end
  assign pad_oe_o = route.pad_en;

  // slot 0 is the constant-zero return for unrouted interfaces
  assign dst_rsp = {pad_i[1], pad_i[0], adp_rsp_i[1], adp_rsp_i[0], {DW{1'b0}}};

  for (genvar i = 0; i < N_IFC; i++) begin : g_ifc
    xbar_sel #(.N(N_DST), .SW(DST_W), .DW(DW)) u_sel (
      .d_i(dst_rsp), .sel_i(route.ifc_dst[i]), .en_i(1'b1), .q_o(ifc_rsp_o[i])
    );
  end

  assign adp_slave_o  = route.adp_slave;
  assign bridge_att_o = route.attached;
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk #(
  parameter int            AW   = 8,
  parameter int            DW   = 8,
  parameter logic [AW-1:0] ADDR = 8'h30
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_en_i,
  input logic [AW-1:0]       addr_i,
  input logic [31:0]         wr_mask_i,
  input logic [31:0]         cfg_q,
  input logic [2:0]          mode_q,
  input logic [1:0][DW-1:0]  pad_o,
  input logic [1:0]          pad_oe_o,
  input logic [1:0]          adp_slave_o,
  input logic [1:0]          bridge_att_o
);
  p_mask_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR) |=> ((cfg_q & ~$past(wr_mask_i)) == ($past(cfg_q) & ~$past(wr_mask_i))));

  p_other_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR) |=> $stable(cfg_q));

  p_rsvd_never_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q[2]);

  p_att0_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd2) |-> (!bridge_att_o[0] && bridge_att_o[1]));

  p_att1_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd3) |-> (!bridge_att_o[1] && bridge_att_o[0]));

  p_slave_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(adp_slave_o));

  p_slave_att_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adp_slave_o[0] |-> !bridge_att_o[0]) and (adp_slave_o[1] |-> !bridge_att_o[1]));

  p_pad0_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pad_oe_o[0] |-> (pad_o[0] == '0));

  p_pad1_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pad_oe_o[1] |-> (pad_o[1] == '0));
endmodule

bind ata_sata_xbar xbar_chk #(.AW(AW), .DW(DW), .ADDR(ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .wr_mask_i(wr_mask_i), .cfg_q(cfg_q), .mode_q(mode_q), .pad_o(pad_o),
  .pad_oe_o(pad_oe_o), .adp_slave_o(adp_slave_o), .bridge_att_o(bridge_att_o)
);

// File: tb/sim_ata_sata_xbar.sv
module sim_ata_sata_xbar;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] addr = 8'h30;
  logic [31:0] wdata = '0, wmask = '0, rd_data;
  logic [3:0][DW-1:0] ifc_req = '0, ifc_rsp;
  logic [1:0][DW-1:0] adp_req, adp_rsp = '0, pad_o, pad_i = '0;
  logic [1:0] adp_slave, pad_oe, att;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_reg = '0;
  // per mode: source of adapter0, adapter1, pad slot0, pad slot1 (-1 unused)
  int tbl[4][4] = '{'{0, 2, -1, 1}, '{0, 2, -1, 3}, '{3, 2, 0, 1}, '{0, 1, 2, 3}};

  always #4 clk = ~clk;

  ata_sata_xbar #(.AW(8), .DW(DW), .ADDR(8'h30)) u0 (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata),
    .wr_mask_i(wmask), .rd_data_o(rd_data), .ifc_req_i(ifc_req), .ifc_rsp_o(ifc_rsp),
    .adp_req_o(adp_req), .adp_rsp_i(adp_rsp), .adp_slave_o(adp_slave),
    .pad_o(pad_o), .pad_oe_o(pad_oe), .pad_i(pad_i), .bridge_att_o(att)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic [31:0] m);
    logic [31:0] nv;
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; wmask = m;
    @(negedge clk);
    wr_en = 1'b0;
    if (a == 8'h30) begin
      nv = (exp_reg & ~m) | (d & m);
      if (nv[26:24] > 3) nv[26:24] = exp_reg[26:24];
      exp_reg = nv;
    end
  endtask

  task automatic verify(int base);
    int m = int'(exp_reg[26:24]);
    string tag;
    tag = (m == 0) ? "R3" : (m == 1) ? "R4" : (m == 2) ? "R5" : "R6";
    for (int i = 0; i < 4; i++) ifc_req[i] = DW'(base + i);
    for (int k = 0; k < 2; k++) begin
      adp_rsp[k] = DW'(base + 8'h40 + k);
      pad_i[k]   = DW'(base + 8'h80 + k);
    end
    addr = 8'h30;
    #1;
    chk("R2 readback", rd_data, exp_reg);
    for (int k = 0; k < 2; k++) chk(tag, 32'(adp_req[k]), 32'(DW'(base + tbl[m][k])));
    for (int k = 0; k < 2; k++) begin
      if (tbl[m][2 + k] < 0) begin
        chk("R10 oe", 32'(pad_oe[k]), 0);
        chk("R10 data", 32'(pad_o[k]), 0);
      end else begin
        chk(tag, 32'(pad_oe[k]), 1);
        chk(tag, 32'(pad_o[k]), 32'(DW'(base + tbl[m][2 + k])));
      end
    end
    for (int i = 0; i < 4; i++) begin
      int d = -1;
      logic [DW-1:0] e;
      for (int k = 0; k < 4; k++) if (tbl[m][k] == i) d = k;
      if (d < 0) chk("R11", 32'(ifc_rsp[i]), 0);
      else begin
        e = (d < 2) ? DW'(base + 8'h40 + d) : DW'(base + 8'h80 + d - 2);
        chk(tag, 32'(ifc_rsp[i]), 32'(e));
      end
    end
    chk("R8", 32'(att), {30'd0, m != 3, m != 2});
    chk("R9", 32'(adp_slave), {30'd0, m == 3, m == 2});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    addr = 8'h30; #1;
    chk("R1", rd_data, 32'h0);
    verify(8'h05);

    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 8; c++)
        for (int mk = 0; mk < 2; mk++) begin
          logic [31:0] d;
          wr(8'h30, 32'(s) << 24, 32'h0700_0000);
          d = 32'h5A3C_00C3 ^ (32'(s * 8 + c) << 8);
          d[26:24] = 3'(c);
          wr(8'h30, d, mk ? 32'h0700_0000 : 32'hFFFF_FFFF);
          addr = 8'h30; #1;
          chk(c > 3 ? "R7" : "R2", rd_data, exp_reg);
          verify(s * 16 + c * 2 + mk);
        end

    wr(8'h30, 32'h0200_0000, 32'h0700_0000);
    wr(8'h34, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    addr = 8'h34; #1;
    chk("R2 other read", rd_data, 32'h0);
    verify(8'h21);
    wr(8'h30, 32'h0300_FFFF, 32'h0000_FFFF);
    verify(8'h33);
    wr(8'h30, 32'h0600_0000, 32'h0400_0000);
    chk("R7 merged", {29'd0, exp_reg[26:24]}, 32'd2);
    verify(8'h44);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule